// File: doc/BRIEF.md
# Bipolar Line Decoder with Error Monitors

This block sits on the receive side of a coaxial line interface, after clock recovery. Each cycle of the recovered clock it samples one line symbol as a pair of rails: one rail for a positive mark, one for a negative mark, neither for a space. It turns that symbol stream into NRZ data under one of three line codes: plain alternate mark inversion, or one of two zero-substitution codes. The substitution codes swap runs of three or four spaces for short patterns that carry a deliberate polarity violation.

While decoding, the block finds and strobes four kinds of event, each for one cycle:
- bipolar violations that are not part of a substitution pattern;
- code violations, where a violation repeats the polarity of the previous one;
- excessive-zero runs;
- received substitution codewords.

Three saturating performance counters add up the bipolar-violation, code-violation and excessive-zero strobes. A one-second tick or a manual request copies each count into a holding register and starts a new interval.

A pass-through select sends the raw rails out instead of decoded data. A loss-of-signal input forces the output to zero.

Top module: `bpd_line_decoder`

## Requirements
- R1: `mode_i` selects the line code: 0 is AMI, 1 is the three-space substitution code, 2 is the four-space substitution code, and 3 behaves as AMI. In binary output mode (`bipolar_i`=0), `out_pos_o` is 1 for each symbol with exactly one rail high. It appears after the fifth rising clock edge that follows the symbol being sampled, counting the sampling edge as the first.
- R2: In mode 1, a violation whose preceding symbol was a space is a codeword. It pulses `cw_o` one cycle after the violation is sampled, and the violation and the two symbols before it are all decoded as zeros.
- R3: In mode 2, a violation whose two preceding symbols were spaces is a codeword. It pulses `cw_o`, and the violation and the three symbols before it are decoded as zeros.
- R4: A violation is a single-rail pulse with the same polarity as the previous pulse. A violation that is not a codeword pulses `bpv_o` one cycle after it is sampled. The first pulse after reset is never a violation.
- R5: `cv_o` pulses for a violation in mode 1 or 2 whose polarity equals that of the previous violation. It also pulses, in any mode, for a symbol with both rails high. Such a symbol decodes as zero and leaves the polarity history unchanged.
- R6: `exz_o` pulses once per run of spaces, on the 3rd space in mode 1, the 4th in mode 2, and the 16th in AMI.
- R7: With `bipolar_i`=1, `out_pos_o` and `out_neg_o` carry the raw rails with the R1 latency. With `bipolar_i`=0, `out_neg_o` is 0.
- R8: When `los_i` is high at the edge that loads the output register, both outputs go to 0 after that edge.
- R9: A latch event (`sec_tick_i` or `latch_req_i` high at an edge) copies every live count into its holding output and restarts the live count. An event strobe that is high at that same edge is counted in the new interval. A strobe increments its counter at the edge after the one that raised it.
- R10: Counters saturate at 2^CNT_W-1 and do not wrap.
- R11: While reset is held, both outputs, all strobes and all holding outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pos_i | input | 1 | Positive-mark rail |
| neg_i | input | 1 | Negative-mark rail |
| mode_i | input | 2 | Line code select |
| bipolar_i | input | 1 | 1: pass raw rails out; 0: decoded NRZ |
| los_i | input | 1 | Loss of signal; squelches output |
| sec_tick_i | input | 1 | One-second latch strobe |
| latch_req_i | input | 1 | Manual latch request |
| out_pos_o | output | 1 | NRZ data or positive rail |
| out_neg_o | output | 1 | Negative rail in pass-through, else 0 |
| bpv_o | output | 1 | Bipolar violation strobe |
| cv_o | output | 1 | Code violation strobe |
| exz_o | output | 1 | Excessive zeros strobe |
| cw_o | output | 1 | Substitution codeword strobe |
| bpv_hold_o | output | CNT_W | Latched bipolar violation count |
| cv_hold_o | output | CNT_W | Latched code violation count |
| exz_hold_o | output | CNT_W | Latched excessive zeros count |

## Verification
The embedded properties assume that the line-code select stays constant during a stream of symbols. For example, the check that an excessive-zeros strobe never repeats on the next cycle holds only while the code select is stable. The stimulus therefore changes the code select and the pass-through select only while reset is held, and waits for the synchronised reset release before sending symbols. Rails that are both high are not excluded: the stimulus drives them on purpose, because the design must classify them. The latch inputs are treated as ordinary single-cycle strobes and may coincide with event strobes.

// File: rtl/bpd_pkg.sv
`timescale 1ns/1ps
package bpd_pkg;
  typedef enum logic [1:0] {
    MODE_AMI   = 2'd0,
    MODE_B3ZS  = 2'd1,
    MODE_HDB3  = 2'd2,
    MODE_AMI_X = 2'd3
  } line_mode_e;

  // one line symbol as it moves through the look-ahead window
  typedef struct packed {
    logic p;
    logic n;
    logic mark;
  } sym_t;

  localparam int EV_BPV    = 0;
  localparam int EV_CV     = 1;
  localparam int EV_EXZ    = 2;
  localparam int EV_CW     = 3;
  localparam int NUM_EV    = 4;
  localparam int NUM_CNT   = 3;
  localparam int WIN_DEPTH = 4;
endpackage

// File: rtl/bpd_sym_window.sv
`timescale 1ns/1ps
module bpd_sym_window
  import bpd_pkg::*;
#(
  parameter int DEPTH = WIN_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pos_i,
  input  logic             neg_i,
  input  logic [DEPTH-1:0] clr_i,
  output logic [1:0]       zero_o,
  output sym_t             tail_o
);
  sym_t [DEPTH-1:0] stage_q;
  sym_t [DEPTH-1:0] stage_d;

  // next state: shift one place; a cleared slot keeps its rails but loses its mark
  always_comb begin
    stage_d[0].p    = pos_i;
    stage_d[0].n    = neg_i;
    stage_d[0].mark = (pos_i ^ neg_i) & ~clr_i[0];
    for (int i = 1; i < DEPTH; i++) begin
      stage_d[i]      = stage_q[i-1];
      stage_d[i].mark = stage_q[i-1].mark & ~clr_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  // raw line spaces of the two most recent symbols, for codeword matching
  always_comb begin
    for (int i = 0; i < 2; i++) zero_o[i] = ~(stage_q[i].p | stage_q[i].n);
  end

  assign tail_o = stage_q[DEPTH-1];
endmodule

// File: rtl/bpd_event_detect.sv
`timescale 1ns/1ps
module bpd_event_detect
  import bpd_pkg::*;
#(
  parameter int DEPTH       = WIN_DEPTH,
  parameter int RUN_W       = 5,
  parameter int AMI_EXZ_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pos_i,
  input  logic              neg_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        zero_prev_i,
  output logic [DEPTH-1:0]  clr_o,
  output logic [NUM_EV-1:0] ev_o
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  localparam logic [DEPTH-1:0] CLR_3   = DEPTH'(3'b111);
  localparam logic [DEPTH-1:0] CLR_4   = DEPTH'(4'b1111);

  line_mode_e mode;
  logic pulse, both, space, viol, sub3, sub4;
  logic is_cw, is_cv, is_bpv, is_exz;
  logic [RUN_W-1:0] thr_m1;

  logic has_pulse_q, has_pulse_d;
  logic last_pos_q, last_pos_d;
  logic has_viol_q, has_viol_d;
  logic last_vpos_q, last_vpos_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [NUM_EV-1:0] ev_q, ev_d;

  always_comb begin
    mode  = line_mode_e'(mode_i);
    sub3  = (mode == MODE_B3ZS);
    sub4  = (mode == MODE_HDB3);
    pulse = pos_i ^ neg_i;
    both  = pos_i & neg_i;
    space = ~(pos_i | neg_i);
    viol  = pulse & has_pulse_q & (pos_i == last_pos_q);

    is_cw  = viol & ((sub3 & zero_prev_i[0]) |
                     (sub4 & zero_prev_i[0] & zero_prev_i[1]));
    is_bpv = viol & ~is_cw;
    is_cv  = both | (viol & (sub3 | sub4) & has_viol_q & (pos_i == last_vpos_q));

    case (mode)
      MODE_B3ZS: thr_m1 = RUN_W'(2);
      MODE_HDB3: thr_m1 = RUN_W'(3);
      default:   thr_m1 = RUN_W'(AMI_EXZ_LEN - 1);
    endcase
    is_exz = space & (run_q == thr_m1);

    if (space)      run_d = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
    else            run_d = '0;

    has_pulse_d = has_pulse_q | pulse;
    last_pos_d  = pulse ? pos_i : last_pos_q;
    has_viol_d  = has_viol_q | viol;
    last_vpos_d = viol ? pos_i : last_vpos_q;

    if (is_cw) clr_o = sub4 ? CLR_4 : CLR_3;
    else       clr_o = '0;

    ev_d          = '0;
    ev_d[EV_BPV]  = is_bpv;
    ev_d[EV_CV]   = is_cv;
    ev_d[EV_EXZ]  = is_exz;
    ev_d[EV_CW]   = is_cw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      has_pulse_q <= 1'b0;
      last_pos_q  <= 1'b0;
      has_viol_q  <= 1'b0;
      last_vpos_q <= 1'b0;
      run_q       <= '0;
      ev_q        <= '0;
    end else begin
      has_pulse_q <= has_pulse_d;
      last_pos_q  <= last_pos_d;
      has_viol_q  <= has_viol_d;
      last_vpos_q <= last_vpos_d;
      run_q       <= run_d;
      ev_q        <= ev_d;
    end
  end

  assign ev_o = ev_q;

  assert_both_rails_cv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_i && neg_i) |=> ev_q[EV_CV]);

  assert_cw_subst_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q[EV_CW] |-> (($past(mode_i) == MODE_B3ZS) || ($past(mode_i) == MODE_HDB3)));

  assert_exz_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q[EV_EXZ] && $stable(mode_i)) |=> !ev_q[EV_EXZ]);
endmodule

// File: rtl/bpd_perf_counter.sv
`timescale 1ns/1ps
module bpd_perf_counter #(
  parameter int CNT_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             latch_i,
  output logic [CNT_W-1:0] hold_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] live_q, live_d;
  logic [CNT_W-1:0] hold_q, hold_d;

  always_comb begin
    live_d = live_q;
    hold_d = hold_q;
    if (latch_i) begin
      hold_d = live_q;
      live_d = {{(CNT_W-1){1'b0}}, inc_i};
    end else if (inc_i && (live_q != CNT_MAX)) begin
      live_d = live_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      hold_q <= '0;
    end else begin
      live_q <= live_d;
      hold_q <= hold_d;
    end
  end

  assign hold_o = hold_q;

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    latch_i |=> ((live_q == '0) || (live_q == CNT_W'(1))));

  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_i && (live_q == CNT_MAX)) |=> (live_q == CNT_MAX));
endmodule

// File: rtl/bpd_line_decoder.sv
`timescale 1ns/1ps
module bpd_line_decoder
  import bpd_pkg::*;
#(
  parameter int CNT_W       = 26,
  parameter int RUN_W       = 5,
  parameter int AMI_EXZ_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pos_i,
  input  logic             neg_i,
  input  logic [1:0]       mode_i,
  input  logic             bipolar_i,
  input  logic             los_i,
  input  logic             sec_tick_i,
  input  logic             latch_req_i,
  output logic             out_pos_o,
  output logic             out_neg_o,
  output logic             bpv_o,
  output logic             cv_o,
  output logic             exz_o,
  output logic             cw_o,
  output logic [CNT_W-1:0] bpv_hold_o,
  output logic [CNT_W-1:0] cv_hold_o,
  output logic [CNT_W-1:0] exz_hold_o
);
  localparam int DEPTH = WIN_DEPTH;

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [DEPTH-1:0]  clr_w;
  logic [1:0]        zero_w;
  sym_t              tail_w;
  logic [NUM_EV-1:0] ev_w;
  logic              latch_w;
  logic [CNT_W-1:0]  hold_w [NUM_CNT];
  logic              out_p_q, out_p_d, out_n_q, out_n_d;

  // reset: asserted at once, released on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  bpd_sym_window #(.DEPTH(DEPTH)) u_window (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pos_i  (pos_i),
    .neg_i  (neg_i),
    .clr_i  (clr_w),
    .zero_o (zero_w),
    .tail_o (tail_w)
  );

  bpd_event_detect #(
    .DEPTH       (DEPTH),
    .RUN_W       (RUN_W),
    .AMI_EXZ_LEN (AMI_EXZ_LEN)
  ) u_detect (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .pos_i       (pos_i),
    .neg_i       (neg_i),
    .mode_i      (mode_i),
    .zero_prev_i (zero_w),
    .clr_o       (clr_w),
    .ev_o        (ev_w)
  );

  assign latch_w = sec_tick_i | latch_req_i;

  generate
    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
      bpd_perf_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .inc_i   (ev_w[c]),
        .latch_i (latch_w),
        .hold_o  (hold_w[c])
      );
    end
  endgenerate

  // output stage: squelch, then binary or pass-through selection
  always_comb begin
    if (los_i) begin
      out_p_d = 1'b0;
      out_n_d = 1'b0;
    end else if (bipolar_i) begin
      out_p_d = tail_w.p;
      out_n_d = tail_w.n;
    end else begin
      out_p_d = tail_w.mark;
      out_n_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_p_q <= 1'b0;
      out_n_q <= 1'b0;
    end else begin
      out_p_q <= out_p_d;
      out_n_q <= out_n_d;
    end
  end

  assign out_pos_o  = out_p_q;
  assign out_neg_o  = out_n_q;
  assign bpv_o      = ev_w[EV_BPV];
  assign cv_o       = ev_w[EV_CV];
  assign exz_o      = ev_w[EV_EXZ];
  assign cw_o       = ev_w[EV_CW];
  assign bpv_hold_o = hold_w[EV_BPV];
  assign cv_hold_o  = hold_w[EV_CV];
  assign exz_hold_o = hold_w[EV_EXZ];

  assert_los_squelch_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    los_i |=> (!out_pos_o && !out_neg_o));
endmodule

// File: tb/bpd_line_decoder_tb_top.sv
`timescale 1ns/1ps
module bpd_line_decoder_tb_top;
  localparam int CW   = 4;
  localparam int CMAX = 15;
  localparam int NSYM = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic pos, neg, bip, los, tick, req;
  logic [1:0] mode;
  logic out_pos, out_neg, bpv, cv, exz, cw;
  logic [CW-1:0] bpv_h, cv_h, exz_h;

  always #2.5 clk = ~clk;

  bpd_line_decoder #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pos_i(pos), .neg_i(neg), .mode_i(mode),
    .bipolar_i(bip), .los_i(los), .sec_tick_i(tick), .latch_req_i(req),
    .out_pos_o(out_pos), .out_neg_o(out_neg), .bpv_o(bpv), .cv_o(cv),
    .exz_o(exz), .cw_o(cw), .bpv_hold_o(bpv_h), .cv_hold_o(cv_h),
    .exz_hold_o(exz_h)
  );

  typedef struct {
    int idx;
    bit bpv;
    bit cv;
    bit exz;
    bit cw;
  } exp_t;
  exp_t ev_q[$];

  bit raw_p[NSYM], raw_n[NSYM], dmark[NSYM], los_a[NSYM];
  int idx;
  bit m_has_pulse, m_last_p, m_has_viol, m_last_vp;
  int m_run;
  int m_cnt[3], m_pend[3], m_hold[3];
  int total, bad;
  bit done;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic model_reset();
    idx = 0;
    m_has_pulse = 0; m_last_p = 0; m_has_viol = 0; m_last_vp = 0; m_run = 0;
    for (int c = 0; c < 3; c++) begin m_cnt[c] = 0; m_pend[c] = 0; m_hold[c] = 0; end
  endtask

  // driver: drives one symbol and pushes its expected events to the scoreboard
  task automatic send(bit p, bit n, bit l = 0, bit t = 0, bit r = 0);
    bit pulse, both, space, viol, cwb, cvb, bpvb, exzb, z1, z2, subst;
    int thr, back;
    int evv[3];
    @(negedge clk);
    pos = p; neg = n; los = l; tick = t; req = r;
    pulse = p ^ n; both = p & n; space = !(p | n);
    z1 = (idx >= 1) ? !(raw_p[idx-1] | raw_n[idx-1]) : 1'b1;
    z2 = (idx >= 2) ? !(raw_p[idx-2] | raw_n[idx-2]) : 1'b1;
    subst = (mode == 2'd1) || (mode == 2'd2);
    viol = pulse && m_has_pulse && (p == m_last_p);
    cwb  = viol && (((mode == 2'd1) && z1) || ((mode == 2'd2) && z1 && z2));
    bpvb = viol && !cwb;
    cvb  = both || (viol && subst && m_has_viol && (p == m_last_vp));
    thr  = (mode == 2'd1) ? 3 : (mode == 2'd2) ? 4 : 16;
    exzb = space && (m_run == thr - 1);
    m_run = space ? ((m_run < 31) ? m_run + 1 : 31) : 0;
    if (viol)  begin m_has_viol = 1; m_last_vp = p; end
    if (pulse) begin m_has_pulse = 1; m_last_p = p; end
    raw_p[idx] = p; raw_n[idx] = n; dmark[idx] = pulse; los_a[idx] = l;
    if (cwb) begin
      back = (mode == 2'd2) ? 3 : 2;
      dmark[idx] = 0;
      for (int k = 1; k <= back; k++) if (idx - k >= 0) dmark[idx-k] = 0;
    end
    evv[0] = bpvb; evv[1] = cvb; evv[2] = exzb;
    for (int c = 0; c < 3; c++) begin
      if (t || r) begin m_hold[c] = m_cnt[c]; m_cnt[c] = m_pend[c]; end
      else m_cnt[c] = (m_cnt[c] + m_pend[c] > CMAX) ? CMAX : m_cnt[c] + m_pend[c];
      m_pend[c] = evv[c];
    end
    ev_q.push_back('{idx, bpvb, cvb, exzb, cwb});
    idx++;
  endtask

  task automatic sym(bit p, bit n);
    send(p, n);
  endtask

  task automatic zeros(int cnt);
    for (int i = 0; i < cnt; i++) send(0, 0);
  endtask

  task automatic check_counts(string tag);
    @(posedge clk); #1;
    chk({tag, " bpv hold"}, 32'(bpv_h), m_hold[0]);
    chk({tag, " cv hold"},  32'(cv_h),  m_hold[1]);
    chk({tag, " exz hold"}, 32'(exz_h), m_hold[2]);
  endtask

  task automatic do_reset(bit [1:0] md, bit bp);
    @(negedge clk);
    rst_n = 0; pos = 0; neg = 0; los = 0; tick = 0; req = 0;
    mode = md; bip = bp;
    ev_q.delete();
    model_reset();
    repeat (3) @(negedge clk);
    chk("R11 out_pos in reset", 32'(out_pos), 0);
    chk("R11 out_neg in reset", 32'(out_neg), 0);
    chk("R11 strobes in reset", 32'({bpv, cv, exz, cw}), 0);
    chk("R11 holds in reset", 32'({bpv_h, cv_h, exz_h}), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  // monitor: pops one expected item per sampled symbol
  initial begin
    exp_t e;
    int j;
    bit ep, en;
    string tg;
    forever begin
      @(posedge clk); #1;
      if (ev_q.size() > 0) begin
        e = ev_q.pop_front();
        chk("R4 bpv strobe", 32'(bpv), e.bpv);
        chk("R5 cv strobe",  32'(cv),  e.cv);
        chk("R6 exz strobe", 32'(exz), e.exz);
        chk("R2 R3 cw strobe", 32'(cw), e.cw);
        if (e.idx >= 4) begin
          j = e.idx - 4;
          if (los_a[e.idx]) begin ep = 0; en = 0; tg = "R8"; end
          else if (bip)     begin ep = raw_p[j]; en = raw_n[j]; tg = "R7"; end
          else              begin ep = dmark[j]; en = 0; tg = "R1"; end
          chk({tg, " out_pos"}, 32'(out_pos), ep);
          chk({tg, " out_neg"}, 32'(out_neg), en);
        end
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    pos = 0; neg = 0; los = 0; tick = 0; req = 0; mode = 2'd0; bip = 0;
    total = 0; bad = 0; done = 0;
    model_reset();
    #1 rst_n = 0;

    // AMI binary: alternation, violations, both rails, long zero run (R1 R4 R5 R6 R9)
    do_reset(2'd0, 0);
    sym(1,0); sym(0,1); sym(1,0); sym(0,0); sym(0,1); sym(0,0); sym(0,0);
    sym(1,0); sym(1,0); sym(0,1); sym(1,1); sym(0,1);
    zeros(17); sym(1,0);
    zeros(5); send(0,0,0,0,1); check_counts("R9 ami");
    zeros(5); send(0,0,0,0,1); check_counts("R9 ami second");

    // mode 3 acts as AMI (R1)
    do_reset(2'd3, 0);
    sym(1,0); sym(0,0); sym(0,0); sym(1,0); sym(0,1); zeros(6);

    // three-space code, binary (R2 R5 R6)
    do_reset(2'd1, 0);
    sym(1,0); sym(0,0); sym(0,0); sym(1,0);
    sym(0,1); sym(0,0); sym(0,1);
    sym(0,0); sym(0,0); sym(0,1);
    sym(1,0); sym(1,0);
    sym(0,0); sym(0,0); sym(0,0); sym(1,0);
    zeros(6); send(0,0,0,1,0); check_counts("R9 b3 tick");

    // four-space code, pass-through, then LOS (R3 R7 R8)
    do_reset(2'd2, 1);
    sym(1,0); sym(0,0); sym(0,0); sym(0,0); sym(1,0);
    sym(0,1); sym(0,0); sym(0,0); sym(0,1);
    zeros(4); sym(1,0);
    for (int i = 0; i < 6; i++) send(i[0], !i[0], 1);
    zeros(6);

    // four-space code, binary, latch in the cycle of a strobe (R3 R4 R9)
    do_reset(2'd2, 0);
    sym(1,0); sym(0,0); sym(0,0); sym(0,0); sym(1,0);
    sym(0,1); sym(0,0); sym(0,0); sym(0,1);
    sym(1,0); sym(0,0); sym(1,0);
    sym(1,0); send(0,0,0,0,1); check_counts("R9 same cycle");
    zeros(4); send(0,0,0,1,0); check_counts("R9 next interval");
    zeros(6);

    // saturation (R10)
    do_reset(2'd0, 0);
    sym(1,0);
    for (int i = 0; i < 18; i++) sym(1,0);
    zeros(3); send(0,0,0,0,1); check_counts("R10 saturate");
    zeros(3); send(0,0,0,0,1); check_counts("R10 restart");
    zeros(4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule